// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counters

This unit holds two wide event counters for a processor core. Each counter has its own select register that picks one event code and a flag that lets it run. The same code can stand for a different event on each counter. Codes 0 (cycles) and 1 (completed instructions) mean the same thing on both. Several paired codes split into a "total" meaning on counter 0 and a "failed" or "missed" meaning on counter 1. The unit runs on the core's gated clock, so it stops when the core clock stops.

Some events are raw pulses from the pipeline. Others are built inside the unit. These are a merged stall cycle (the OR of two stall causes), a data-TLB miss count that treats chained misses as one, three fill-level buckets for a queue, and a cacheable-read latency and request pair. Dividing the latency count by the request count gives the average miss latency.

Software reaches four registers through a simple port, and each counter has a sticky overflow output.

Top module: `dual_perf_counters`

## Requirements
- R1: After reset both counters read zero, both select registers read zero (disabled, code 0) and both overflow outputs are low.
- R2: Code 0 adds one per clock on either counter while the counter is enabled.
- R3: Code 1 adds one per clock in which `instr_done` is high, on either counter.
- R4: Code 2 counts `branch_done` cycles on counter 0 and `branch_mispred` cycles on counter 1.
- R5: A code that has no meaning for a counter never changes it. Examples are code 7 on both counters, code 63 on counter 1, code 6 on counter 0 and code 18 on counter 1.
- R6: Code 18 on counter 0 adds one per cycle in which `stall_fetch` or `stall_lsu` is high, and only one when both are high.
- R7: Code 6 on counter 1 counts a `dtlb_miss` pulse only when no earlier counted miss is still waiting for its `dtlb_refill`. A refill clears the wait.
- R8: With D the queue depth, code 50 counts cycles in which `q_fill` < D/4 on counter 0, and cycles in which D/4 <= `q_fill` <= D/2 on counter 1. Code 51 on counter 0 counts cycles in which `q_fill` > D/2.
- R9: Code 61 on counter 0 adds one per cycle from the cycle after a cacheable `miss_start` up to and including the `crit_return` cycle. On counter 1 it counts each cacheable `miss_start`. An uncached start adds to neither counter.
- R10: A select register holds the event code in bits 5:0 and the enable in bit 6. A disabled counter keeps its value.
- R11: When a counter steps from all-ones it wraps to zero and sets its overflow output. The output stays high until software writes that counter, which clears it.
- R12: A software write to a counter wins over an increment in the same cycle.
- R13: Register addresses are 0 for select 0, 1 for select 1, 2 for counter 0 and 3 for counter 1. Writes take effect at the clock edge. Reads return the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gated core clock |
| rst_n | input | 1 | Active-low reset |
| instr_done | input | 1 | Instruction completed this cycle |
| branch_done | input | 1 | Branch completed this cycle |
| branch_mispred | input | 1 | Completed branch was mispredicted |
| dtlb_miss | input | 1 | Data-TLB miss pulse |
| dtlb_refill | input | 1 | Data-TLB entry refilled |
| stall_fetch | input | 1 | Stall cause from fetch |
| stall_lsu | input | 1 | Stall cause from load/store unit |
| q_fill | input | OCC_W | Current queue fill level |
| miss_start | input | 1 | Read miss detected |
| miss_cacheable | input | 1 | The detected miss is cacheable |
| crit_return | input | 1 | Critical doubleword returned |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | CNT_W | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | CNT_W | Read data |
| ovf | output | 2 | Sticky overflow flag per counter |

## Verification
The bench builds the block with a 32-bit counter width and a queue depth of 12. With that depth the bucket edges fall at fill levels 3 and 6, and every edge can be driven exactly, including both values at the middle bucket's ends. The full 32-bit width is kept, and a counter is preloaded near all-ones, so the wrap and the sticky overflow appear within a few cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int SEL_W = 6;

    localparam logic [SEL_W-1:0] EV_CYCLE  = 6'd0;
    localparam logic [SEL_W-1:0] EV_INSTR  = 6'd1;
    localparam logic [SEL_W-1:0] EV_BRANCH = 6'd2;
    localparam logic [SEL_W-1:0] EV_DTLB   = 6'd6;
    localparam logic [SEL_W-1:0] EV_STALL  = 6'd18;
    localparam logic [SEL_W-1:0] EV_OCC_A  = 6'd50;
    localparam logic [SEL_W-1:0] EV_OCC_B  = 6'd51;
    localparam logic [SEL_W-1:0] EV_LAT    = 6'd61;

    typedef struct packed {
        logic instr;
        logic branch;
        logic mispred;
        logic dtlb_cnt;
        logic stall_any;
        logic occ_low;
        logic occ_mid;
        logic occ_high;
        logic lat_busy;
        logic lat_req;
    } evt_bus_t;

endpackage

// File: rtl/pmu_event_derive.sv
module pmu_event_derive
    import pmu_pkg::*;
#(
    parameter int QDEPTH = 16,
    parameter int OCC_W  = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done,
    input  logic             branch_done,
    input  logic             branch_mispred,
    input  logic             dtlb_miss,
    input  logic             dtlb_refill,
    input  logic             stall_fetch,
    input  logic             stall_lsu,
    input  logic [OCC_W-1:0] q_fill,
    input  logic             miss_start,
    input  logic             miss_cacheable,
    input  logic             crit_return,
    output evt_bus_t         evt
);

    localparam int QUART = QDEPTH / 4;
    localparam int HALF  = QDEPTH / 2;

    typedef struct packed {
        logic pend;
        logic busy;
    } dstate_t;

    dstate_t st_d, st_q;
    logic    req_c;

    always_comb begin
        req_c     = miss_start & miss_cacheable;
        st_d.pend = (st_q.pend & ~dtlb_refill) | dtlb_miss;
        st_d.busy = (st_q.busy & ~crit_return) | req_c;

        evt           = '0;
        evt.instr     = instr_done;
        evt.branch    = branch_done;
        evt.mispred   = branch_mispred;
        evt.dtlb_cnt  = dtlb_miss & ~st_q.pend;
        evt.stall_any = stall_fetch | stall_lsu;
        evt.occ_low   = q_fill <  OCC_W'(QUART);
        evt.occ_mid   = (q_fill >= OCC_W'(QUART)) && (q_fill <= OCC_W'(HALF));
        evt.occ_high  = q_fill >  OCC_W'(HALF);
        evt.lat_busy  = st_q.busy;
        evt.lat_req   = req_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DTLB_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (dtlb_miss && !dtlb_refill) |=> !evt.dtlb_cnt || !dtlb_miss); // R7

    AST_LAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_return && !miss_start) |=> !evt.lat_busy); // R9

endmodule

// File: rtl/pmu_event_mux.sv
module pmu_event_mux
    import pmu_pkg::*;
#(
    parameter int CTR_IDX = 0
) (
    input  logic [SEL_W-1:0] sel,
    input  evt_bus_t         evt,
    output logic             hit
);

    logic hit0_c, hit1_c;

    always_comb begin
        unique case (sel)
            EV_CYCLE:  hit0_c = 1'b1;
            EV_INSTR:  hit0_c = evt.instr;
            EV_BRANCH: hit0_c = evt.branch;
            EV_STALL:  hit0_c = evt.stall_any;
            EV_OCC_A:  hit0_c = evt.occ_low;
            EV_OCC_B:  hit0_c = evt.occ_high;
            EV_LAT:    hit0_c = evt.lat_busy;
            default:   hit0_c = 1'b0;
        endcase
        unique case (sel)
            EV_CYCLE:  hit1_c = 1'b1;
            EV_INSTR:  hit1_c = evt.instr;
            EV_BRANCH: hit1_c = evt.mispred;
            EV_DTLB:   hit1_c = evt.dtlb_cnt;
            EV_OCC_A:  hit1_c = evt.occ_mid;
            EV_LAT:    hit1_c = evt.lat_req;
            default:   hit1_c = 1'b0;
        endcase
        hit = (CTR_IDX == 0) ? hit0_c : hit1_c;
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             hit,
    output logic [SEL_W-1:0] sel,
    output logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.en  = wdata[SEL_W];
            st_d.sel = wdata[SEL_W-1:0];
        end
        if (cnt_we) begin
            st_d.cnt = wdata;
            st_d.ovf = 1'b0;
        end else if (st_q.en && hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;
    assign en  = st_q.en;
    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt == $past(wdata)); // R12

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_we) |=> $stable(cnt)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cnt_we) |=> ovf); // R11

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2

endmodule

// File: rtl/dual_perf_counters.sv
module dual_perf_counters
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int QDEPTH = 16,
    localparam int OCC_W = $clog2(QDEPTH + 1),
    localparam int NCTR  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done,
    input  logic             branch_done,
    input  logic             branch_mispred,
    input  logic             dtlb_miss,
    input  logic             dtlb_refill,
    input  logic             stall_fetch,
    input  logic             stall_lsu,
    input  logic [OCC_W-1:0] q_fill,
    input  logic             miss_start,
    input  logic             miss_cacheable,
    input  logic             crit_return,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic [1:0]       reg_raddr,
    output logic [CNT_W-1:0] reg_rdata,
    output logic [NCTR-1:0]  ovf
);

    evt_bus_t         evt;
    logic [SEL_W-1:0] sel_w [NCTR];
    logic             en_w  [NCTR];
    logic [CNT_W-1:0] cnt_w [NCTR];
    logic             hit_w [NCTR];

    pmu_event_derive #(.QDEPTH(QDEPTH), .OCC_W(OCC_W)) u_derive (
        .clk(clk), .rst_n(rst_n),
        .instr_done(instr_done), .branch_done(branch_done),
        .branch_mispred(branch_mispred),
        .dtlb_miss(dtlb_miss), .dtlb_refill(dtlb_refill),
        .stall_fetch(stall_fetch), .stall_lsu(stall_lsu),
        .q_fill(q_fill),
        .miss_start(miss_start), .miss_cacheable(miss_cacheable),
        .crit_return(crit_return),
        .evt(evt)
    );

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        pmu_event_mux #(.CTR_IDX(i)) u_mux (
            .sel(sel_w[i]), .evt(evt), .hit(hit_w[i])
        );
        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(reg_we && reg_addr == 2'(i)),
            .cnt_we(reg_we && reg_addr == 2'(2 + i)),
            .wdata(reg_wdata),
            .hit(hit_w[i]),
            .sel(sel_w[i]), .en(en_w[i]), .cnt(cnt_w[i]), .ovf(ovf[i])
        );
    end

    always_comb begin
        unique case (reg_raddr)
            2'd0:    reg_rdata = {{(CNT_W-SEL_W-1){1'b0}}, en_w[0], sel_w[0]};
            2'd1:    reg_rdata = {{(CNT_W-SEL_W-1){1'b0}}, en_w[1], sel_w[1]};
            2'd2:    reg_rdata = cnt_w[0];
            default: reg_rdata = cnt_w[1];
        endcase
    end

endmodule

// File: tb/dual_perf_counters_bench.sv
`timescale 1ns/1ps
module dual_perf_counters_bench;

    localparam int CNT_W  = 32;
    localparam int QDEPTH = 12;
    localparam int OCC_W  = $clog2(QDEPTH + 1);
    localparam int RUN_N  = 5;
    localparam int NROW   = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_done = 0, branch_done = 0, branch_mispred = 0;
    logic dtlb_miss = 0, dtlb_refill = 0, stall_fetch = 0, stall_lsu = 0;
    logic [OCC_W-1:0] q_fill = '0;
    logic miss_start = 0, miss_cacheable = 0, crit_return = 0;
    logic reg_we = 0;
    logic [1:0] reg_addr = '0, reg_raddr = '0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_perf_counters #(.CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_dual_perf_counters (
        .clk(clk), .rst_n(rst_n),
        .instr_done(instr_done), .branch_done(branch_done),
        .branch_mispred(branch_mispred),
        .dtlb_miss(dtlb_miss), .dtlb_refill(dtlb_refill),
        .stall_fetch(stall_fetch), .stall_lsu(stall_lsu),
        .q_fill(q_fill),
        .miss_start(miss_start), .miss_cacheable(miss_cacheable),
        .crit_return(crit_return),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .ovf(ovf)
    );

    typedef struct packed {
        logic [5:0]  s0;
        logic [5:0]  s1;
        logic        ins;
        logic        br;
        logic        mis;
        logic        sa;
        logic        sb;
        logic [3:0]  occ;
        logic [3:0]  rq;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    // each active event counts RUN_N+2 edges per row
    localparam vec_t TBL [NROW] = '{
        '{6'd0,  6'd0,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd0, 4'd2,  32'd7, 32'd7}, // R2
        '{6'd1,  6'd1,  1'b1,1'b0,1'b0,1'b0,1'b0, 4'd0, 4'd3,  32'd7, 32'd7}, // R3
        '{6'd1,  6'd1,  1'b0,1'b0,1'b0,1'b0,1'b0, 4'd0, 4'd3,  32'd0, 32'd0}, // R3
        '{6'd2,  6'd2,  1'b0,1'b1,1'b0,1'b0,1'b0, 4'd0, 4'd4,  32'd7, 32'd0}, // R4
        '{6'd2,  6'd2,  1'b0,1'b1,1'b1,1'b0,1'b0, 4'd0, 4'd4,  32'd7, 32'd7}, // R4
        '{6'd18, 6'd18, 1'b0,1'b0,1'b0,1'b1,1'b1, 4'd0, 4'd6,  32'd7, 32'd0}, // R6 once per cycle; R5 on counter 1
        '{6'd18, 6'd0,  1'b0,1'b0,1'b0,1'b0,1'b1, 4'd0, 4'd6,  32'd7, 32'd7}, // R6
        '{6'd50, 6'd50, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2, 4'd8,  32'd7, 32'd0}, // R8 below quarter
        '{6'd50, 6'd50, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3, 4'd8,  32'd0, 32'd7}, // R8 at quarter
        '{6'd50, 6'd50, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6, 4'd8,  32'd0, 32'd7}, // R8 at half
        '{6'd51, 6'd50, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7, 4'd8,  32'd7, 32'd0}, // R8 above half
        '{6'd7,  6'd63, 1'b1,1'b1,1'b1,1'b1,1'b1, 4'd9, 4'd5,  32'd0, 32'd0}, // R5
        '{6'd6,  6'd6,  1'b1,1'b1,1'b1,1'b1,1'b1, 4'd9, 4'd5,  32'd0, 32'd0}  // R5 counter 0 code 6
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        reg_raddr = a;
        #0.3;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        #(4.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_chk(2'd0, 32'h0, "R1");
        rd_chk(2'd1, 32'h0, "R1");
        rd_chk(2'd2, 32'h0, "R1");
        rd_chk(2'd3, 32'h0, "R1");
        check("R1", {30'd0, ovf}, 32'h0);
        idle(1);

        for (int k = 0; k < NROW; k++) begin
            instr_done = TBL[k].ins; branch_done = TBL[k].br;
            branch_mispred = TBL[k].mis; stall_fetch = TBL[k].sa;
            stall_lsu = TBL[k].sb; q_fill = TBL[k].occ;
            wr(2'd2, 32'd0);
            wr(2'd3, 32'd0);
            wr(2'd0, {25'd0, 1'b1, TBL[k].s0});
            wr(2'd1, {25'd0, 1'b1, TBL[k].s1});
            idle(RUN_N);
            wr(2'd0, 32'd0);
            wr(2'd1, 32'd0);
            rd_chk(2'd2, TBL[k].e0, $sformatf("R%0d row %0d counter 0", TBL[k].rq, k));
            rd_chk(2'd3, TBL[k].e1, $sformatf("R%0d row %0d counter 1", TBL[k].rq, k));
            idle(1);
        end
        instr_done = 0; branch_done = 0; branch_mispred = 0;
        stall_fetch = 0; stall_lsu = 0; q_fill = '0;

        // R13 select readback, R10 disabled counter holds
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h12);
        stall_fetch = 1;
        idle(4);
        stall_fetch = 0;
        rd_chk(2'd0, 32'h12, "R13");
        rd_chk(2'd2, 32'h0, "R10");
        idle(1);

        // R7 chained data-TLB misses
        wr(2'd3, 32'd0);
        wr(2'd1, 32'h46);
        dtlb_miss = 1; idle(1);
        idle(1);
        dtlb_miss = 0; dtlb_refill = 1; idle(1);
        dtlb_refill = 0; dtlb_miss = 1; idle(1);
        dtlb_miss = 0; dtlb_refill = 1; idle(1);
        dtlb_refill = 0; dtlb_miss = 1; idle(1);
        dtlb_miss = 0; dtlb_refill = 1; idle(1);
        dtlb_refill = 0;
        wr(2'd1, 32'd0);
        rd_chk(2'd3, 32'd3, "R7");
        idle(1);

        // R9 latency and request count
        wr(2'd2, 32'd0);
        wr(2'd3, 32'd0);
        wr(2'd0, 32'h7D);
        wr(2'd1, 32'h7D);
        miss_start = 1; miss_cacheable = 1; idle(1);
        miss_start = 0; miss_cacheable = 0; idle(3);
        crit_return = 1; idle(1);
        crit_return = 0; idle(1);
        miss_start = 1; idle(1);
        miss_start = 0; idle(1);
        crit_return = 1; idle(1);
        crit_return = 0;
        miss_start = 1; miss_cacheable = 1; idle(1);
        miss_start = 0; miss_cacheable = 0; crit_return = 1; idle(1);
        crit_return = 0; idle(1);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        rd_chk(2'd2, 32'd5, "R9 latency");
        rd_chk(2'd3, 32'd2, "R9 requests");
        idle(1);

        // R11 wrap and sticky overflow
        wr(2'd2, 32'hFFFF_FFFE);
        wr(2'd0, 32'h40);
        idle(2);
        wr(2'd0, 32'd0);
        rd_chk(2'd2, 32'd1, "R11 wrap");
        check("R11 ovf set", {30'd0, ovf}, 32'h1);
        idle(3);
        check("R11 ovf sticky", {30'd0, ovf}, 32'h1);
        wr(2'd2, 32'd5);
        check("R11 ovf cleared", {30'd0, ovf}, 32'h0);
        rd_chk(2'd2, 32'd5, "R11");
        idle(1);

        // R12 write beats increment
        wr(2'd3, 32'd0);
        wr(2'd1, 32'h40);
        idle(1);
        rd_chk(2'd3, 32'd1, "R2");
        wr(2'd3, 32'd100);
        rd_chk(2'd3, 32'd100, "R12");
        idle(1);
        rd_chk(2'd3, 32'd101, "R12");
        wr(2'd1, 32'd0);
        rd_chk(2'd3, 32'd102, "R12");

        summary();
        $finish;
    end

endmodule